// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block gathers the event pulses of a USB host/slave controller into one sticky 8-bit status register and drives a single interrupt request line. The transfer engines raise done pulses for the two transfer slots. The frame timer raises a pulse at each frame start. The line monitor raises pulses for attach or detach, for wake-up or detect, and for the data-plus line state. Each pulse sets its own status bit. The bit stays set until software clears it.

Software reaches the block through a simple processor bus port. It can read the status register and the enable register, write the enable register, and clear status bits by writing ones to the status address. The enable register only gates which set status bits reach the request output. Status bits latch whether or not they are enabled, so software can also poll for events with the request line masked.

The request output is a registered OR of the status bits ANDed with the enable bits. It therefore changes no earlier than one clock after the state that drives it.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset the status register and the enable register are all zeros. The request output is low and the read data output is zero.
- R2: A high level on `evt_i[n]` at a rising clock edge sets status bit n, for n in the implemented set {0,1,4,5,6,7}. Bit 0 is slot A done, bit 1 is slot B done, bit 4 is frame timer, bit 5 is attach/detach, bit 6 is detect/resume and bit 7 is data-plus state. A set bit stays set until it is cleared, and this holds whatever value the enable register has.
- R3: A bus write to address 0x0D clears every status bit whose written data bit is 1 and leaves every bit whose written data bit is 0 unchanged.
- R4: When an event pulse and a write-one clear reach the same status bit at the same edge, the bit ends up set.
- R5: A bus write to address 0x06 loads the enable register, and a read of 0x06 returns it.
- R6: `irq_o` equals the OR over all bits of (status AND enable) as they stood one clock earlier, so it follows any status or enable change by exactly one cycle.
- R7: Bits 2 and 3 are reserved in both registers. They read as zero and ignore events and bus writes.
- R8: A read from any address other than 0x0D or 0x06 returns zero, and a write to such an address changes neither register.
- R9: Read data is registered. With `bus_rd` high at an edge, `bus_rdata` shows the addressed register's value from before that edge. With `bus_rd` low, `bus_rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 8 | Event pulses, one per status bit |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event pulse or a clear write changes status at the edge that samples it. The request output follows one edge later, and read data reflects state one edge after the read strobe. The bench drives every stimulus on a falling edge and samples its results on a falling edge. For the request output it waits one extra full cycle after the status or enable change, and it first confirms that the line has not moved early. Reads are issued only in cycles with no event or write active, so each read returns settled register contents.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int unsigned UIC_DW = 8;
  localparam int unsigned UIC_AW = 8;
  localparam int unsigned BIT_SLOT_A = 0;
  localparam int unsigned BIT_SLOT_B = 1;
  localparam int unsigned BIT_FRAME  = 4;
  localparam int unsigned BIT_ATTACH = 5;
  localparam int unsigned BIT_WAKE   = 6;
  localparam int unsigned BIT_DPLUS  = 7;
  localparam logic [UIC_DW-1:0] UIC_VALID =
    (UIC_DW'(1) << BIT_SLOT_A) | (UIC_DW'(1) << BIT_SLOT_B) |
    (UIC_DW'(1) << BIT_FRAME)  | (UIC_DW'(1) << BIT_ATTACH) |
    (UIC_DW'(1) << BIT_WAKE)   | (UIC_DW'(1) << BIT_DPLUS);
  localparam logic [UIC_AW-1:0] UIC_STAT_ADDR = 8'h0D;
  localparam logic [UIC_AW-1:0] UIC_EN_ADDR   = 8'h06;

  typedef struct packed {
    logic hit_stat;
    logic hit_en;
  } uic_sel_t;
endpackage

// File: rtl/uic_decode.sv
module uic_decode #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h0D,
  parameter logic [AW-1:0] EN_ADDR   = 8'h06
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  output uic_pkg::uic_sel_t sel,
  output logic              wr_stat,
  output logic              wr_en
);
  always_comb begin
    sel.hit_stat = (addr == STAT_ADDR);
    sel.hit_en   = (addr == EN_ADDR);
    wr_stat      = wr && sel.hit_stat;
    wr_en        = wr && sel.hit_en;
  end
endmodule

// File: rtl/uic_stat_bit.sv
module uic_stat_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/uic_en_reg.sv
module uic_en_reg #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d & VALID;
  end
endmodule

// File: rtl/uic_req.sv
module uic_req #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] en,
  output logic          req
);
  logic pend;
  assign pend = |(stat & en);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= pend;
  end
endmodule

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl #(
  parameter int unsigned DW = uic_pkg::UIC_DW,
  parameter int unsigned AW = uic_pkg::UIC_AW,
  parameter logic [DW-1:0] VALID = uic_pkg::UIC_VALID,
  parameter logic [AW-1:0] STAT_ADDR = uic_pkg::UIC_STAT_ADDR,
  parameter logic [AW-1:0] EN_ADDR   = uic_pkg::UIC_EN_ADDR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  uic_pkg::uic_sel_t sel;
  logic              wr_stat;
  logic              wr_en;
  logic [DW-1:0]     stat_q;
  logic [DW-1:0]     en_q;
  logic [DW-1:0]     set_v;
  logic [DW-1:0]     clr_v;

  uic_decode #(.AW(AW), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .sel(sel), .wr_stat(wr_stat), .wr_en(wr_en)
  );

  assign set_v = evt_i & VALID;
  assign clr_v = wr_stat ? (bus_wdata & VALID) : '0;

  for (genvar i = 0; i < DW; i++) begin : g_stat
    uic_stat_bit u_bit (
      .clk(clk), .rst(rst), .set_i(set_v[i]), .clr_i(clr_v[i]), .q(stat_q[i])
    );
  end

  uic_en_reg #(.DW(DW), .VALID(VALID)) u_en (
    .clk(clk), .rst(rst), .ld(wr_en), .d(bus_wdata), .q(en_q)
  );

  uic_req #(.DW(DW)) u_req (
    .clk(clk), .rst(rst), .stat(stat_q), .en(en_q), .req(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (sel.hit_stat)    bus_rdata <= stat_q;
      else if (sel.hit_en) bus_rdata <= en_q;
      else                 bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/usb_irq_ctrl_chk.sv
module usb_irq_ctrl_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  parameter logic [DW-1:0] VALID = '1,
  parameter logic [AW-1:0] STAT_ADDR = 8'h0D,
  parameter logic [AW-1:0] EN_ADDR   = 8'h06
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] evt_i,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          irq_o,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] en_q
);
  logic [DW-1:0] clr_req;
  assign clr_req = (bus_wr && bus_addr == STAT_ADDR) ? bus_wdata : '0;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && en_q == '0 && !irq_o)); // R1
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_req)) == $past(stat_q & ~clr_req))); // R2
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(clr_req & ~evt_i)) == '0)); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_req & evt_i & VALID)) |=>
      ((stat_q & $past(clr_req & evt_i & VALID)) == $past(clr_req & evt_i & VALID))); // R4
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == EN_ADDR) |=> (en_q == $past(bus_wdata & VALID))); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == EN_ADDR) |=> $stable(en_q)); // R8
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(stat_q & en_q)))); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~VALID) == '0) && ((en_q & ~VALID) == '0)); // R7
endmodule

bind usb_irq_ctrl usb_irq_ctrl_chk #(
  .DW(DW), .AW(AW), .VALID(VALID), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .stat_q(stat_q), .en_q(en_q)
);

// File: tb/sim_usb_irq_ctrl.sv
module sim_usb_irq_ctrl;
  localparam logic [7:0] MASK = 8'hF3;
  localparam logic [7:0] A_ST = 8'h0D;
  localparam logic [7:0] A_EN = 8'h06;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_i = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_irq_ctrl u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_i = e;
    tick();
    evt_i = '0;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    repeat (3) tick();
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst = 1'b0;
    tick();
    rd(A_ST, v); check("R1 status", v, 8'h00);
    rd(A_EN, v); check("R1 enable", v, 8'h00);

    // R2 R7: every event pattern latches with enable off
    for (int p = 0; p < 256; p++) begin
      wr(A_ST, 8'hFF);
      pulse(8'(p));
      tick();
      rd(A_ST, v); check("R2 R7 latch", v, 8'(p) & MASK);
      check("R2 no irq when masked", {7'd0, irq_o}, 8'h00);
    end

    // R3: clear patterns over a full status
    for (int c = 0; c < 256; c++) begin
      pulse(8'hFF);
      wr(A_ST, 8'(c));
      rd(A_ST, v); check("R3 clear", v, MASK & ~8'(c));
    end

    // R4: event and clear together
    for (int p = 1; p < 256; p += 7) begin
      wr(A_ST, 8'hFF);
      evt_i = 8'(p);
      wr(A_ST, 8'hFF);
      evt_i = '0;
      rd(A_ST, v); check("R4 event wins", v, 8'(p) & MASK);
    end

    // R5 R6 R7: enable sweep against status patterns
    for (int p = 0; p < 256; p += 5) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] e;
        e = (k == 0) ? 8'(p) : (k == 1) ? ~8'(p) : (k == 2) ? 8'(p * 3) : 8'hFF;
        wr(A_ST, 8'hFF);
        pulse(8'(p));
        wr(A_EN, e);
        rd(A_EN, v); check("R5 R7 enable", v, e & MASK);
        check("R6 irq", {7'd0, irq_o}, {7'd0, |(8'(p) & e & MASK)});
      end
    end

    // R6 latency from event
    wr(A_ST, 8'hFF);
    wr(A_EN, 8'h10);
    tick();
    check("R6 idle", {7'd0, irq_o}, 8'h00);
    evt_i = 8'h10;
    tick();
    evt_i = '0;
    check("R6 not early", {7'd0, irq_o}, 8'h00);
    tick();
    check("R6 one cycle late", {7'd0, irq_o}, 8'h01);
    wr(A_ST, 8'h10);
    check("R6 clear not early", {7'd0, irq_o}, 8'h01);
    tick();
    check("R6 drop after clear", {7'd0, irq_o}, 8'h00);

    // R8: other addresses
    pulse(8'h81);
    wr(8'h20, 8'hFF);
    wr(8'h05, 8'hFF);
    rd(A_ST, v); check("R8 status kept", v, 8'h81);
    rd(A_EN, v); check("R8 enable kept", v, 8'h10);
    rd(8'h0E, v); check("R8 unmapped read", v, 8'h00);

    // R9: read data holds without strobe
    rd(A_ST, held);
    pulse(8'h40);
    tick();
    check("R9 hold", bus_rdata, held);
    rd(A_ST, v); check("R9 new read", v, 8'hC1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got 00 expected 01");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule